// File: doc/BRIEF.md
# DMA Shared-Bus Cycle Arbiter

The arbiter decides, cycle by cycle, who owns a shared external bus. Six requesters compete for it: three DMA channels ranked 0A, 0B and 1, a memory refresh requester, an external bus-release requester and a low-rank transfer helper. Each request is a pulse, or a level, that the arbiter latches and holds until it is served. A served request is cleared in the same edge that grants it. The arbiter drives one cycle-type code per clock and a one-hot grant for the DMA channel that owns the bus.

A DMA transfer is a run of read/write pairs. The run length comes from a per-channel length input, sampled when the channel is selected. A read is always followed at once by its write. During a run, the channel choice is locked, and refresh or bus release can be slipped in only directly after a write. A channel marked as targeting on-chip memory needs no external slot for those services, so they are granted in the same cycle as its read or write. The helper only gets the bus when the DMA side is idle and has nothing pending. A one-cycle done pulse follows the last write of every run.

Top module: `dma_bus_arb`

## Requirements
- R1: Once a channel starts a run, chan_gnt_o shows only that channel until the run's last write. Pending requests from higher-ranked channels wait. chan_gnt_o is never more than one-hot.
- R2: A read cycle (cyc_o = 1) is always followed in the next cycle by the write cycle (cyc_o = 2) of the same channel, with no other cycle between them.
- R3: In a run whose channel targets external memory, a pending refresh (cyc_o = 3) or bus release (cyc_o = 4) is placed only directly after a write that is not the last one. The channel's next read follows in the cycle after it.
- R4: The helper cycle (cyc_o = 5, hlp_gnt_o = 1) is granted only from idle, with no DMA run active and no DMA request pending.
- R5: From idle, the arbiter picks in this fixed order: refresh, then bus release, then channel 0A (chan_req_i bit 0), then 0B (bit 1), then 1 (bit 2), then helper. A refresh or bus release that is granted from idle returns to idle afterwards.
- R6: A request pulse is held until that source is granted. It is served exactly once, and it is cleared on the edge that grants it.
- R7: The cycle after a run's last write is always idle (cyc_o = 0), with done_o high for that single cycle. A new run only starts from idle.
- R8: For a channel whose chan_onchip_i bit was set when the run started, a pending refresh or bus release is granted in the next read or write cycle of the run, through ref_gnt_o or brel_gnt_o. No separate cycle is inserted for it.
- R9: A run consists of chan_len_i pairs for the selected channel, 4 bits per channel, with channel k at bits 4k+3..4k. A length of 0 gives one pair.
- R10: While rst_ni is low, and after it is released, the arbiter is idle with every grant and done_o low and all held requests dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_req_i | input | NCH (3) | DMA channel requests, bit 0 = 0A, bit 1 = 0B, bit 2 = 1 |
| chan_len_i | input | NCH*LW (12) | Per-channel run length in read/write pairs |
| chan_onchip_i | input | NCH (3) | Per-channel flag: the run targets on-chip memory |
| ref_req_i | input | 1 | Refresh request |
| brel_req_i | input | 1 | External bus-release request |
| hlp_req_i | input | 1 | Helper transfer request |
| cyc_o | output | 3 | Cycle type: 0 idle, 1 read, 2 write, 3 refresh, 4 bus release, 5 helper |
| chan_gnt_o | output | NCH (3) | One-hot grant of the channel doing a read or write |
| ref_gnt_o | output | 1 | Refresh granted, either as its own cycle or alongside an on-chip access |
| brel_gnt_o | output | 1 | Bus release granted, either as its own cycle or alongside an on-chip access |
| hlp_gnt_o | output | 1 | Helper cycle granted |
| done_o | output | 1 | One-cycle pulse after the last write of a run |

## Verification
A request sampled at a rising edge can change cyc_o and the grants from that same edge onward. So a request driven in cycle n first shows in cycle n+1. The done pulse shows in the cycle after the last write. Concurrent on-chip grants appear together with the read or write they ride on. The bench drives every input on the falling edge and reads every output on the next falling edge, half a period after the register update. Its directed sequences list the expected code for each successive cycle. A cycle-level model, advanced on the same rising edge as the design, supplies the expected values for the random phase.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE = 3'd0,
    CYC_RD   = 3'd1,
    CYC_WR   = 3'd2,
    CYC_REF  = 3'd3,
    CYC_BREL = 3'd4,
    CYC_HLP  = 3'd5
  } cyc_e;
endpackage

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign eff_o[g] = q[g] | set_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= 1'b0;
      else         q[g] <= eff_o[g] & ~clr_i[g];
    end

    AST_HELD_UNTIL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q[g] && !clr_i[g]) |=> q[g]); // R6
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int W  = 3,
  parameter int IW = 2
) (
  input  logic [W-1:0]  req_i,
  output logic [W-1:0]  oh_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        oh_o    = '0;
        oh_o[i] = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  AST_PICK_ONEHOT: assert final ((req_i == '0) ? (oh_o == '0) : $onehot(oh_o)); // R5
endmodule

// File: rtl/dma_arb_seq.sv
module dma_arb_seq
  import dma_arb_pkg::*;
#(
  parameter int NCH = 3,
  parameter int LW  = 4,
  parameter int CW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    dma_p_i,
  input  logic              ref_p_i,
  input  logic              brel_p_i,
  input  logic              hlp_p_i,
  input  logic [NCH*LW-1:0] len_i,
  input  logic [NCH-1:0]    onchip_i,
  input  logic [NCH-1:0]    pick_oh_i,
  input  logic [CW-1:0]     pick_idx_i,
  output logic [NCH-1:0]    dma_clr_o,
  output logic              ref_clr_o,
  output logic              brel_clr_o,
  output logic              hlp_clr_o,
  output logic [2:0]        cyc_o,
  output logic [NCH-1:0]    ch_gnt_o,
  output logic              ref_gnt_o,
  output logic              brel_gnt_o,
  output logic              hlp_gnt_o,
  output logic              done_o
);
  cyc_e          st_q, st_d;
  logic [CW-1:0] ch_q, ch_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          busy_q, busy_d;
  logic          onc_q, onc_d;
  logic          sref_q, sref_d;
  logic          sbrel_q, sbrel_d;
  logic          done_q, done_d;
  logic          dma_cyc;
  logic [LW-1:0] len_a [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_len
    assign len_a[g] = len_i[g*LW +: LW];
  end

  always_comb begin
    st_d       = st_q;
    ch_d       = ch_q;
    rem_d      = rem_q;
    busy_d     = busy_q;
    onc_d      = onc_q;
    done_d     = 1'b0;
    sref_d     = 1'b0;
    sbrel_d    = 1'b0;
    dma_clr_o  = '0;
    ref_clr_o  = 1'b0;
    brel_clr_o = 1'b0;
    hlp_clr_o  = 1'b0;
    case (st_q)
      CYC_IDLE: begin
        if (ref_p_i) begin
          st_d      = CYC_REF;
          ref_clr_o = 1'b1;
        end else if (brel_p_i) begin
          st_d       = CYC_BREL;
          brel_clr_o = 1'b1;
        end else if (|dma_p_i) begin
          st_d      = CYC_RD;
          ch_d      = pick_idx_i;
          dma_clr_o = pick_oh_i;
          rem_d     = (len_a[pick_idx_i] == '0) ? LW'(1) : len_a[pick_idx_i];
          busy_d    = 1'b1;
          onc_d     = onchip_i[pick_idx_i];
        end else if (hlp_p_i) begin
          st_d      = CYC_HLP;
          hlp_clr_o = 1'b1;
        end
      end
      CYC_RD: st_d = CYC_WR;
      CYC_WR: begin
        if (rem_q <= LW'(1)) begin
          st_d   = CYC_IDLE;
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          rem_d = rem_q - LW'(1);
          // insertion slot only for externally targeted runs
          if (!onc_q && ref_p_i) begin
            st_d      = CYC_REF;
            ref_clr_o = 1'b1;
          end else if (!onc_q && brel_p_i) begin
            st_d       = CYC_BREL;
            brel_clr_o = 1'b1;
          end else begin
            st_d = CYC_RD;
          end
        end
      end
      CYC_REF, CYC_BREL: st_d = busy_q ? CYC_RD : CYC_IDLE;
      default: st_d = CYC_IDLE;
    endcase
    // on-chip access: services ride along with the DMA cycle
    if ((st_d == CYC_RD || st_d == CYC_WR) && onc_d) begin
      sref_d     = ref_p_i;
      sbrel_d    = brel_p_i;
      ref_clr_o  = ref_clr_o | ref_p_i;
      brel_clr_o = brel_clr_o | brel_p_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CYC_IDLE;
      ch_q    <= '0;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      onc_q   <= 1'b0;
      sref_q  <= 1'b0;
      sbrel_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ch_q    <= ch_d;
      rem_q   <= rem_d;
      busy_q  <= busy_d;
      onc_q   <= onc_d;
      sref_q  <= sref_d;
      sbrel_q <= sbrel_d;
      done_q  <= done_d;
    end
  end

  assign dma_cyc    = (st_q == CYC_RD) || (st_q == CYC_WR);
  assign cyc_o      = st_q;
  assign ref_gnt_o  = (st_q == CYC_REF) | sref_q;
  assign brel_gnt_o = (st_q == CYC_BREL) | sbrel_q;
  assign hlp_gnt_o  = (st_q == CYC_HLP);
  assign done_o     = done_q;

  for (genvar g = 0; g < NCH; g++) begin : g_gnt
    assign ch_gnt_o[g] = dma_cyc && (ch_q == CW'(g));
  end

  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CYC_RD) |=> (st_q == CYC_WR) && $stable(ch_q)); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CYC_WR) |-> ($past(st_q) == CYC_RD)); // R2
  AST_CH_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(ch_q)); // R1
  AST_INSERT_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == CYC_REF || st_q == CYC_BREL) && busy_q) |-> ($past(st_q) == CYC_WR) && !onc_q); // R3
  AST_HLP_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CYC_HLP) |-> ($past(st_q) == CYC_IDLE) && !busy_q); // R4
  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ($past(st_q) == CYC_IDLE)); // R7
  AST_DONE_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(st_q) == CYC_WR) && (st_q == CYC_IDLE)); // R7
  AST_SIDE_ONCHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sref_q || sbrel_q) |-> onc_q && dma_cyc); // R8
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb #(
  parameter int NCH = 3,
  parameter int LW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    chan_req_i,
  input  logic [NCH*LW-1:0] chan_len_i,
  input  logic [NCH-1:0]    chan_onchip_i,
  input  logic              ref_req_i,
  input  logic              brel_req_i,
  input  logic              hlp_req_i,
  output logic [2:0]        cyc_o,
  output logic [NCH-1:0]    chan_gnt_o,
  output logic              ref_gnt_o,
  output logic              brel_gnt_o,
  output logic              hlp_gnt_o,
  output logic              done_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NS = NCH + 3;

  logic [NS-1:0]  hold_set, hold_clr, hold_eff;
  logic [NCH-1:0] dma_clr, pick_oh;
  logic [CW-1:0]  pick_idx;
  logic           ref_clr, brel_clr, hlp_clr;

  assign hold_set = {hlp_req_i, brel_req_i, ref_req_i, chan_req_i};
  assign hold_clr = {hlp_clr, brel_clr, ref_clr, dma_clr};

  dma_arb_hold #(.W(NS)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hold_set),
    .clr_i  (hold_clr),
    .eff_o  (hold_eff)
  );

  dma_arb_pick #(.W(NCH), .IW(CW)) i_pick (
    .req_i (hold_eff[NCH-1:0]),
    .oh_o  (pick_oh),
    .idx_o (pick_idx)
  );

  dma_arb_seq #(.NCH(NCH), .LW(LW), .CW(CW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dma_p_i    (hold_eff[NCH-1:0]),
    .ref_p_i    (hold_eff[NCH]),
    .brel_p_i   (hold_eff[NCH+1]),
    .hlp_p_i    (hold_eff[NCH+2]),
    .len_i      (chan_len_i),
    .onchip_i   (chan_onchip_i),
    .pick_oh_i  (pick_oh),
    .pick_idx_i (pick_idx),
    .dma_clr_o  (dma_clr),
    .ref_clr_o  (ref_clr),
    .brel_clr_o (brel_clr),
    .hlp_clr_o  (hlp_clr),
    .cyc_o      (cyc_o),
    .ch_gnt_o   (chan_gnt_o),
    .ref_gnt_o  (ref_gnt_o),
    .brel_gnt_o (brel_gnt_o),
    .hlp_gnt_o  (hlp_gnt_o),
    .done_o     (done_o)
  );

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_gnt_o)); // R1
  AST_HLP_NOT_WITH_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlp_gnt_o |-> (chan_gnt_o == '0) && !done_o); // R4
endmodule

// File: tb/test_dma_bus_arb.sv
module test_dma_bus_arb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  chan_req_i = '0;
  logic [11:0] chan_len_i = '0;
  logic [2:0]  chan_onchip_i = '0;
  logic        ref_req_i = 1'b0, brel_req_i = 1'b0, hlp_req_i = 1'b0;
  logic [2:0]  cyc_o, chan_gnt_o;
  logic        ref_gnt_o, brel_gnt_o, hlp_gnt_o, done_o;

  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_bus_arb i_dma_bus_arb (
    .clk_i, .rst_ni, .chan_req_i, .chan_len_i, .chan_onchip_i,
    .ref_req_i, .brel_req_i, .hlp_req_i,
    .cyc_o, .chan_gnt_o, .ref_gnt_o, .brel_gnt_o, .hlp_gnt_o, .done_o
  );

  // cycle model built from the requirements
  int m_st, m_ch, m_rem;
  bit m_busy, m_onc, m_sr, m_sb, m_done, m_pr, m_pb, m_ph;
  bit [2:0] m_pd;

  function automatic int len_of(int k);
    int l;
    l = int'(chan_len_i[k*4 +: 4]);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic bit [2:0] exp_gnt();
    return (m_st == 1 || m_st == 2) ? (3'b001 << m_ch) : 3'b000;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_ch = 0; m_rem = 0; m_busy = 0; m_onc = 0;
      m_sr = 0; m_sb = 0; m_done = 0; m_pr = 0; m_pb = 0; m_ph = 0; m_pd = '0;
    end else begin
      bit [2:0] pd;
      bit pr, pb, ph, nsr, nsb;
      int nst;
      pd = m_pd | chan_req_i; pr = m_pr | ref_req_i;
      pb = m_pb | brel_req_i; ph = m_ph | hlp_req_i;
      nst = m_st; nsr = 0; nsb = 0; m_done = 0;
      case (m_st)
        0: begin
          if (pr) begin nst = 3; pr = 0; end
          else if (pb) begin nst = 4; pb = 0; end
          else if (pd != 0) begin
            int k;
            k = pd[0] ? 0 : (pd[1] ? 1 : 2);
            nst = 1; m_ch = k; pd[k] = 0; m_rem = len_of(k);
            m_busy = 1; m_onc = chan_onchip_i[k];
          end else if (ph) begin nst = 5; ph = 0; end
        end
        1: nst = 2;
        2: begin
          if (m_rem <= 1) begin nst = 0; m_busy = 0; m_done = 1; end
          else begin
            m_rem--;
            if (!m_onc && pr) begin nst = 3; pr = 0; end
            else if (!m_onc && pb) begin nst = 4; pb = 0; end
            else nst = 1;
          end
        end
        3, 4: nst = m_busy ? 1 : 0;
        default: nst = 0;
      endcase
      if ((nst == 1 || nst == 2) && m_onc) begin
        nsr = pr; nsb = pb; pr = 0; pb = 0;
      end
      m_st = nst; m_sr = nsr; m_sb = nsb;
      m_pd = pd; m_pr = pr; m_pb = pb; m_ph = ph;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic exp_cg(int cyc, int gnt, string tag);
    chk(int'(cyc_o) == cyc, {tag, " cyc"}, int'(cyc_o), cyc);
    chk(int'(chan_gnt_o) == gnt, {tag, " gnt"}, int'(chan_gnt_o), gnt);
  endtask

  always @(negedge clk_i) begin
    if (model_on && rst_ni) begin
      chk(int'(cyc_o) == m_st, "R5 model cyc", int'(cyc_o), m_st);
      chk(chan_gnt_o == exp_gnt(), "R1 model gnt", int'(chan_gnt_o), int'(exp_gnt()));
      chk(ref_gnt_o == (m_st == 3 || m_sr), "R8 model ref_gnt", int'(ref_gnt_o), int'(m_st == 3 || m_sr));
      chk(brel_gnt_o == (m_st == 4 || m_sb), "R3 model brel_gnt", int'(brel_gnt_o), int'(m_st == 4 || m_sb));
      chk(hlp_gnt_o == (m_st == 5), "R4 model hlp_gnt", int'(hlp_gnt_o), int'(m_st == 5));
      chk(done_o == m_done, "R7 model done", int'(done_o), int'(m_done));
    end
  end

  task automatic settle();
    chan_req_i = '0; ref_req_i = 0; brel_req_i = 0; hlp_req_i = 0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R10: reset state
    exp_cg(0, 0, "R10 in reset");
    chk(done_o == 0 && ref_gnt_o == 0 && brel_gnt_o == 0 && hlp_gnt_o == 0,
        "R10 side outputs", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_cg(0, 0, "R10 after reset");

    // D1: three channels at once, len 1 each
    chan_len_i = {4'd1, 4'd1, 4'd1};
    chan_req_i = 3'b111;
    @(negedge clk_i); chan_req_i = '0;
    exp_cg(1, 1, "R5 0A read");
    @(negedge clk_i); exp_cg(2, 1, "R2 0A write");
    @(negedge clk_i); exp_cg(0, 0, "R7 gap"); chk(done_o, "R7 done 0A", int'(done_o), 1);
    @(negedge clk_i); exp_cg(1, 2, "R5 0B read");
    @(negedge clk_i); exp_cg(2, 2, "R2 0B write");
    @(negedge clk_i); exp_cg(0, 0, "R7 gap");
    @(negedge clk_i); exp_cg(1, 4, "R6 ch1 read held");
    @(negedge clk_i); exp_cg(2, 4, "R2 ch1 write");
    @(negedge clk_i); exp_cg(0, 0, "R7 gap"); chk(done_o, "R7 done ch1", int'(done_o), 1);
    @(negedge clk_i); exp_cg(0, 0, "R6 served once"); chk(!done_o, "R7 done width", int'(done_o), 0);
    settle();

    // D2: refresh, bus release, 0A and helper together
    ref_req_i = 1; brel_req_i = 1; hlp_req_i = 1; chan_req_i = 3'b001;
    @(negedge clk_i); settle_inputs();
    exp_cg(3, 0, "R5 refresh first"); chk(ref_gnt_o, "R5 ref_gnt", int'(ref_gnt_o), 1);
    @(negedge clk_i); exp_cg(0, 0, "R5 back to idle");
    @(negedge clk_i); exp_cg(4, 0, "R5 release second"); chk(brel_gnt_o, "R5 brel_gnt", int'(brel_gnt_o), 1);
    @(negedge clk_i); exp_cg(0, 0, "R5 idle");
    @(negedge clk_i); exp_cg(1, 1, "R5 0A before helper");
    @(negedge clk_i); exp_cg(2, 1, "R2 write");
    @(negedge clk_i); exp_cg(0, 0, "R7 gap");
    @(negedge clk_i); exp_cg(5, 0, "R4 helper last"); chk(hlp_gnt_o, "R4 hlp_gnt", int'(hlp_gnt_o), 1);
    @(negedge clk_i); exp_cg(0, 0, "R4 helper one cycle");
    settle();

    // D3: locked run of 3 on ch1 with refresh insertion and 0A waiting
    chan_len_i = {4'd3, 4'd2, 4'd1};
    chan_req_i = 3'b100;
    @(negedge clk_i); chan_req_i = 3'b001; ref_req_i = 1;
    exp_cg(1, 4, "R1 ch1 read");
    @(negedge clk_i); settle_inputs();
    exp_cg(2, 4, "R1 ch1 write");
    @(negedge clk_i); exp_cg(3, 0, "R3 refresh after write"); chk(ref_gnt_o, "R3 ref_gnt", int'(ref_gnt_o), 1);
    @(negedge clk_i); exp_cg(1, 4, "R3 resume read");
    @(negedge clk_i); exp_cg(2, 4, "R9 pair 2");
    @(negedge clk_i); exp_cg(1, 4, "R1 locked over 0A");
    @(negedge clk_i); exp_cg(2, 4, "R9 pair 3");
    @(negedge clk_i); exp_cg(0, 0, "R9 run ends"); chk(done_o, "R7 done", int'(done_o), 1);
    @(negedge clk_i); exp_cg(1, 1, "R6 0A after run");
    @(negedge clk_i); exp_cg(2, 1, "R2 0A write");
    settle();

    // D4: on-chip 0B, bus release rides along
    chan_onchip_i = 3'b010;
    chan_req_i = 3'b010;
    @(negedge clk_i); chan_req_i = '0; brel_req_i = 1;
    exp_cg(1, 2, "R8 0B read");
    @(negedge clk_i); brel_req_i = 0;
    exp_cg(2, 2, "R8 0B write"); chk(brel_gnt_o, "R8 concurrent brel", int'(brel_gnt_o), 1);
    @(negedge clk_i); exp_cg(1, 2, "R8 no insert"); chk(!brel_gnt_o, "R8 brel once", int'(brel_gnt_o), 0);
    @(negedge clk_i); exp_cg(2, 2, "R8 second write");
    @(negedge clk_i); exp_cg(0, 0, "R7 gap"); chk(done_o, "R7 done", int'(done_o), 1);
    chan_onchip_i = '0;
    settle();

    // D5: length zero gives one pair
    chan_len_i = {4'd1, 4'd1, 4'd0};
    chan_req_i = 3'b001;
    @(negedge clk_i); chan_req_i = '0;
    exp_cg(1, 1, "R9 len0 read");
    @(negedge clk_i); exp_cg(2, 1, "R9 len0 write");
    @(negedge clk_i); exp_cg(0, 0, "R9 len0 one pair"); chk(done_o, "R9 done", int'(done_o), 1);
    settle();

    // D6: reset drops a held request
    chan_req_i = 3'b010; hlp_req_i = 1;
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); settle_inputs(); rst_ni = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      exp_cg(0, 0, "R10 held dropped");
    end

    // random phase against the model
    model_on = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      chan_req_i    = {($urandom % 9) == 0, ($urandom % 9) == 0, ($urandom % 9) == 0};
      ref_req_i     = ($urandom % 17) == 0;
      brel_req_i    = ($urandom % 17) == 0;
      hlp_req_i     = ($urandom % 11) == 0;
      chan_len_i    = 12'($urandom);
      chan_len_i    = chan_len_i & 12'h333;
      chan_onchip_i = 3'($urandom);
      @(negedge clk_i);
    end
    settle_inputs();
    repeat (40) @(negedge clk_i);
    model_on = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic settle_inputs();
    chan_req_i = '0; ref_req_i = 0; brel_req_i = 0; hlp_req_i = 0;
  endtask
endmodule